// File: doc/BRIEF.md
# Memory Version Tag Checker

This block guards data accesses with a small per-line version tag. It holds a 4-bit tag for every 64-byte line of a tag store whose depth is a parameter, and for each request it compares the tag in the top nibble of the pointer against the tag stored for the addressed line. Each request carries the pointer, the physical line index, the program counter, the access kind, the page attributes (tag checking on, writable) and the task controls (master tag enable, precise store error mode).

One cycle after the request, the block answers with a grant or a blocked result and a 2-bit fault code. The code tells a precise mismatch from a tag-disabled rejection and from a deferred store error. A deferred store error stays pending with the program counter of the first offending store until a clear input pulses. Tag-set stores write a new line tag, and block-initialising stores zero it.

Access kind encoding on `req_kind`: 0 load, 1 non-faulting load, 2 store, 3 tag-set store, 4 block-initialising store. Codes 5 to 7 are granted and have no effect. Fault encoding on `rsp_fault`: 00 none, 01 precise mismatch, 10 tag-disabled, 11 deferred mismatch pending.

Top module: `mem_tag_checker`

## Requirements
- R1: A request accepted on a clock edge produces `rsp_valid`=1 with its grant, fault and address after that edge, for exactly one cycle. With no request, `rsp_valid`, `rsp_grant`, `rsp_fault` and `rsp_addr` are all 0, and `rsp_addr` is 0 whenever the fault code is 00.
- R2: The pointer tag is `req_va[63:60]`. It is compared with the tag stored for the line chosen by `req_line`. When they are equal the access is granted.
- R3: A compare happens only when `task_tag_en` and `page_chk_en` are both 1. Otherwise loads and stores are granted with fault 00.
- R4: A pointer tag of 0x0 or 0xF never produces a mismatch, whatever the stored tag is.
- R5: A load (kind 0) that mismatches is blocked (`rsp_grant`=0), reports fault 01, and returns the pointer on `rsp_addr`.
- R6: A store (kind 2) that mismatches while `task_precise`=1 is blocked, reports fault 01, and returns the pointer on `rsp_addr`.
- R7: A store that mismatches while `task_precise`=0 is granted and reports fault 11. It sets `defer_pending`. `defer_pc` takes `req_pc` only if no error was already pending. `rsp_addr` shows the recorded program counter.
- R8: `defer_pending` stays 1 and `defer_pc` stays unchanged until `defer_clr` pulses. When a clear and a new deferred mismatch arrive in the same cycle, the new program counter is recorded and the error stays pending.
- R9: A non-faulting load (kind 1) is always granted with fault 00.
- R10: A tag-set store (kind 3) with `task_tag_en`=1 and `page_writable`=1 writes `req_new_tag` into the line, and the next request already sees the new tag. It is granted with fault 00 and performs no compare.
- R11: A tag-set store with `task_tag_en`=0 is blocked with fault 10, returns the pointer, and leaves the tag unchanged. With the master enable on but `page_writable`=0, it is blocked with fault 00 and leaves the tag unchanged.
- R12: A block-initialising store (kind 4) sets the line tag to 0 and is granted with fault 00, without a compare.
- R13: After reset every stored tag is 0 and no deferred error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind code |
| req_va | input | 64 | Tagged virtual pointer |
| req_line | input | IDX_W | Physical line index into the tag store |
| req_pc | input | 64 | Program counter of the access |
| req_new_tag | input | 4 | Tag value for a tag-set store |
| page_chk_en | input | 1 | Page has tag checking on |
| page_writable | input | 1 | Page is writable |
| task_tag_en | input | 1 | Task master tag enable |
| task_precise | input | 1 | Store mismatches are precise when 1 |
| defer_clr | input | 1 | Clears a pending deferred error |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 2 | Fault code |
| rsp_addr | output | 64 | Faulting pointer or recorded program counter |
| defer_pending | output | 1 | Deferred store error pending |
| defer_pc | output | 64 | Program counter of the first deferred mismatch |

## Verification
A corrupted line tag cannot be seen until that line is read again. It then shows up one cycle later as a wrong grant, or as a fault code 01 or 11 on a load or store with a non-wildcard pointer tag and both enables set. A tag written where none should be, or a clear that was missed, is therefore caught only by a later access to the same line, so the bench reads back each line after every tag update. A wrong deferred-error state shows the cycle after the next mismatching store: either as an overwritten `defer_pc` or through `defer_pending` directly.

// File: rtl/tagchk_pkg.sv
// Shared encodings for the memory version tag checker.
package tagchk_pkg;
    localparam int TAG_W = 4;

    typedef enum logic [2:0] {
        ACC_LOAD    = 3'd0,
        ACC_NFLOAD  = 3'd1,
        ACC_STORE   = 3'd2,
        ACC_TAGSET  = 3'd3,
        ACC_BLKINIT = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_PRECISE = 2'b01,
        FLT_TAGOFF  = 2'b10,
        FLT_DEFER   = 2'b11
    } fault_e;
endpackage

// File: rtl/tagchk_ram.sv
// Tag store: one TAG_W-bit tag per line, asynchronous read, one write port.
// Assumes the writer gates wr_en with a valid request; all tags reset to 0.
module tagchk_ram #(
    parameter int LINES = 64,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] tags [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line tag register, cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tags[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                tags[g] <= wr_tag;
        end
    end

    // Read the addressed line; indices past the depth read as tag 0.
    always_comb begin
        rd_tag = '0;
        if (int'(rd_idx) < LINES)
            rd_tag = tags[rd_idx];
    end
endmodule

// File: rtl/tagchk_defer.sv
// Deferred store-error latch. Keeps the program counter of the first
// deferred mismatch until cleared; a clear and a new error in the same
// cycle leave the new error recorded. rec_pc is the value that will be held.
module tagchk_defer #(
    parameter int PC_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic            clr,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] rec_pc,
    output logic            pending,
    output logic [PC_W-1:0] pc_q
);
    // Program counter that a set in this cycle would leave recorded.
    always_comb rec_pc = (pending && !clr) ? pc_q : pc_in;

    // Pending flag and recorded program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            pc_q    <= '0;
        end else if (set) begin
            pending <= 1'b1;
            pc_q    <= rec_pc;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/tagchk_classify.sv
// Combinational decision for one access: compares the pointer tag with the
// stored line tag under the enables and yields grant, fault code, reported
// address, tag write and deferred-error set. No state.
module tagchk_classify
    import tagchk_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PC_W = 64
) (
    input  logic [2:0]       kind,
    input  logic [VA_W-1:0]  va,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             page_chk_en,
    input  logic             page_writable,
    input  logic             task_tag_en,
    input  logic             task_precise,
    input  logic [PC_W-1:0]  rec_pc,
    output logic             grant,
    output fault_e           fault,
    output logic [VA_W-1:0]  addr,
    output logic             tag_wr,
    output logic [TAG_W-1:0] tag_val,
    output logic             defer_set
);
    localparam logic [TAG_W-1:0] WILD_LO = '0;
    localparam logic [TAG_W-1:0] WILD_HI = '1;

    logic [TAG_W-1:0] ptr_tag;
    logic             mismatch;

    // Pointer tag and whether a checked compare fails.
    always_comb begin
        ptr_tag  = va[VA_W-1 -: TAG_W];
        mismatch = task_tag_en && page_chk_en
                   && (ptr_tag != WILD_LO) && (ptr_tag != WILD_HI)
                   && (ptr_tag != stored_tag);
    end

    // Per-kind outcome.
    always_comb begin
        grant     = 1'b1;
        fault     = FLT_NONE;
        addr      = '0;
        tag_wr    = 1'b0;
        tag_val   = '0;
        defer_set = 1'b0;
        case (acc_kind_e'(kind))
            ACC_LOAD: begin
                if (mismatch) begin
                    grant = 1'b0;
                    fault = FLT_PRECISE;
                    addr  = va;
                end
            end
            ACC_STORE: begin
                if (mismatch && task_precise) begin
                    grant = 1'b0;
                    fault = FLT_PRECISE;
                    addr  = va;
                end else if (mismatch) begin
                    fault     = FLT_DEFER;
                    addr      = VA_W'(rec_pc);
                    defer_set = 1'b1;
                end
            end
            ACC_TAGSET: begin
                if (!task_tag_en) begin
                    grant = 1'b0;
                    fault = FLT_TAGOFF;
                    addr  = va;
                end else if (!page_writable) begin
                    grant = 1'b0;
                end else begin
                    tag_wr  = 1'b1;
                    tag_val = new_tag;
                end
            end
            ACC_BLKINIT: begin
                tag_wr  = 1'b1;
                tag_val = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mem_tag_checker.sv
// Memory version tag checker top. Looks up the line tag, classifies the
// request, updates the tag store and the deferred-error latch, and registers
// the response so it appears one cycle after the request.
// Assumes req_line is below LINES; other fields are sampled only when
// req_valid is 1. defer_clr acts whether or not a request is present.
module mem_tag_checker
    import tagchk_pkg::*;
#(
    parameter int LINES = 64,
    parameter int VA_W  = 64,
    parameter int PC_W  = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [VA_W-1:0]  req_va,
    input  logic [IDX_W-1:0] req_line,
    input  logic [PC_W-1:0]  req_pc,
    input  logic [TAG_W-1:0] req_new_tag,
    input  logic             page_chk_en,
    input  logic             page_writable,
    input  logic             task_tag_en,
    input  logic             task_precise,
    input  logic             defer_clr,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic [1:0]       rsp_fault,
    output logic [VA_W-1:0]  rsp_addr,
    output logic             defer_pending,
    output logic [PC_W-1:0]  defer_pc
);
    logic [TAG_W-1:0] stored_tag;
    logic [TAG_W-1:0] c_tag_val;
    logic [PC_W-1:0]  rec_pc;
    logic [VA_W-1:0]  c_addr;
    logic             c_grant, c_tag_wr, c_defer_set;
    fault_e           c_fault;

    tagchk_ram #(.LINES(LINES), .TAG_W(TAG_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_line),
        .rd_tag (stored_tag),
        .wr_en  (req_valid && c_tag_wr),
        .wr_idx (req_line),
        .wr_tag (c_tag_val)
    );

    tagchk_classify #(.VA_W(VA_W), .PC_W(PC_W)) u_cls (
        .kind          (req_kind),
        .va            (req_va),
        .stored_tag    (stored_tag),
        .new_tag       (req_new_tag),
        .page_chk_en   (page_chk_en),
        .page_writable (page_writable),
        .task_tag_en   (task_tag_en),
        .task_precise  (task_precise),
        .rec_pc        (rec_pc),
        .grant         (c_grant),
        .fault         (c_fault),
        .addr          (c_addr),
        .tag_wr        (c_tag_wr),
        .tag_val       (c_tag_val),
        .defer_set     (c_defer_set)
    );

    tagchk_defer #(.PC_W(PC_W)) u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (req_valid && c_defer_set),
        .clr     (defer_clr),
        .pc_in   (req_pc),
        .rec_pc  (rec_pc),
        .pending (defer_pending),
        .pc_q    (defer_pc)
    );

    // Response register: one-cycle result, all zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_grant <= c_grant;
            rsp_fault <= c_fault;
            rsp_addr  <= c_addr;
        end
    end
endmodule

// File: rtl/tagchk_checker.sv
// Protocol checker for mem_tag_checker, attached by bind below.
module tagchk_checker
    import tagchk_pkg::*;
#(
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic [63:0]      req_va,
    input logic             page_chk_en,
    input logic             task_tag_en,
    input logic             defer_clr,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [1:0]       rsp_fault,
    input logic [63:0]      rsp_addr,
    input logic             defer_pending,
    input logic [63:0]      defer_pc
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant && rsp_fault == 2'b00)); // R1
    AST_CHECK_OFF_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!task_tag_en || !page_chk_en)
         && (req_kind == ACC_LOAD || req_kind == ACC_STORE))
        |=> (rsp_grant && rsp_fault == 2'b00)); // R3
    AST_PRECISE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'b01) |-> (!rsp_grant && rsp_addr == $past(req_va))); // R5
    AST_DEFER_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_pending && $past(defer_pending) && !$past(defer_clr)) |-> $stable(defer_pc)); // R8
    AST_NFLOAD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_NFLOAD) |=> (rsp_grant && rsp_fault == 2'b00)); // R9
    AST_DEFER_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'b11) |-> (defer_pending && rsp_grant && rsp_addr == defer_pc)); // R7
    AST_TAGOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_TAGSET && !task_tag_en) |=> (!rsp_grant && rsp_fault == 2'b10)); // R11
endmodule

bind mem_tag_checker tagchk_checker #(.LINES(LINES)) u_tagchk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_va        (req_va),
    .page_chk_en   (page_chk_en),
    .task_tag_en   (task_tag_en),
    .defer_clr     (defer_clr),
    .rsp_valid     (rsp_valid),
    .rsp_grant     (rsp_grant),
    .rsp_fault     (rsp_fault),
    .rsp_addr      (rsp_addr),
    .defer_pending (defer_pending),
    .defer_pc      (defer_pc)
);

// File: tb/tb_mem_tag_checker.sv
// Directed and random stimulus against a behavioural reference model,
// compared after every clock.
module tb_mem_tag_checker;
    localparam int LINES = 64;
    localparam int IDX_W = $clog2(LINES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_kind = '0;
    logic [63:0]      req_va = '0;
    logic [IDX_W-1:0] req_line = '0;
    logic [63:0]      req_pc = '0;
    logic [3:0]       req_new_tag = '0;
    logic             page_chk_en = 1'b0;
    logic             page_writable = 1'b0;
    logic             task_tag_en = 1'b0;
    logic             task_precise = 1'b0;
    logic             defer_clr = 1'b0;
    logic             rsp_valid, rsp_grant, defer_pending;
    logic [1:0]       rsp_fault;
    logic [63:0]      rsp_addr, defer_pc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int          m_tags [LINES];
    bit          m_pend;
    logic [63:0] m_pc;

    mem_tag_checker #(.LINES(LINES)) dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // Drive one cycle (at a falling edge), predict, then compare at the next falling edge.
    task automatic step(string r, bit v, int kind, logic [63:0] va, int line,
                        logic [63:0] pc, int ntag, bit chk_en, bit wr,
                        bit ten, bit prec, bit clr);
        bit          eg;
        int          ef;
        logic [63:0] ea;
        int          ptag, st;
        bit          mis;
        req_valid = v; req_kind = 3'(kind); req_va = va; req_line = IDX_W'(line);
        req_pc = pc; req_new_tag = 4'(ntag); page_chk_en = chk_en;
        page_writable = wr; task_tag_en = ten; task_precise = prec; defer_clr = clr;
        eg = 1'b0; ef = 0; ea = '0;
        if (clr) m_pend = 1'b0;
        if (v) begin
            eg = 1'b1;
            ptag = int'(va[63:60]);
            st = m_tags[line];
            mis = ten && chk_en && ptag != 0 && ptag != 15 && ptag != st;
            case (kind)
                0: if (mis) begin eg = 1'b0; ef = 1; ea = va; end
                2: if (mis && prec) begin eg = 1'b0; ef = 1; ea = va; end
                   else if (mis) begin
                       if (!m_pend) m_pc = pc;
                       m_pend = 1'b1; ef = 3; ea = m_pc;
                   end
                3: if (!ten) begin eg = 1'b0; ef = 2; ea = va; end
                   else if (!wr) eg = 1'b0;
                   else m_tags[line] = ntag;
                4: m_tags[line] = 0;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(r, "rsp_valid", 64'(rsp_valid), 64'(v));
        chk(r, "rsp_grant", 64'(rsp_grant), 64'(eg));
        chk(r, "rsp_fault", 64'(rsp_fault), 64'(ef));
        chk(r, "rsp_addr", rsp_addr, ea);
        chk(r, "defer_pending", 64'(defer_pending), 64'(m_pend));
        if (m_pend) chk(r, "defer_pc", defer_pc, m_pc);
    endtask

    function automatic logic [63:0] vp(int tag, int line);
        return {4'(tag), 48'h0000_1000_0000, 6'(line), 6'h08};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) m_tags[i] = 0;
        m_pend = 1'b0; m_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state at the ports
        chk("R13", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R13", "defer_pending", 64'(defer_pending), 64'd0);
        step("R1", 0, 0, '0, 0, '0, 0, 1, 1, 1, 1, 0);
        // R13: fresh line reads tag 0, so pointer tag 3 mismatches
        step("R13", 1, 0, vp(3, 5), 5, 64'h10, 0, 1, 1, 1, 1, 0);
        // R10: write tag A, next cycle sees it
        step("R10", 1, 3, vp(1, 3), 3, 64'h14, 10, 1, 1, 1, 1, 0);
        step("R2", 1, 0, vp(10, 3), 3, 64'h18, 0, 1, 1, 1, 1, 0);
        step("R5", 1, 0, vp(5, 3), 3, 64'h1c, 0, 1, 1, 1, 1, 0);
        step("R4", 1, 0, vp(0, 3), 3, 64'h20, 0, 1, 1, 1, 1, 0);
        step("R4", 1, 2, vp(15, 3), 3, 64'h24, 0, 1, 1, 1, 1, 0);
        step("R3", 1, 0, vp(5, 3), 3, 64'h28, 0, 0, 1, 1, 1, 0);
        step("R3", 1, 2, vp(5, 3), 3, 64'h2c, 0, 1, 1, 0, 1, 0);
        step("R9", 1, 1, vp(5, 3), 3, 64'h30, 0, 1, 1, 1, 1, 0);
        step("R6", 1, 2, vp(5, 3), 3, 64'h34, 0, 1, 1, 1, 1, 0);
        step("R7", 1, 2, vp(5, 3), 3, 64'h100, 0, 1, 1, 1, 0, 0);
        step("R7", 1, 2, vp(6, 3), 3, 64'h200, 0, 1, 1, 1, 0, 0);
        step("R8", 0, 0, '0, 0, '0, 0, 1, 1, 1, 0, 0);
        step("R8", 0, 0, '0, 0, '0, 0, 1, 1, 1, 0, 1);
        step("R7", 1, 2, vp(5, 3), 3, 64'h280, 0, 1, 1, 1, 0, 0);
        step("R8", 1, 2, vp(5, 3), 3, 64'h300, 0, 1, 1, 1, 0, 1);
        // R11: rejected tag sets leave tag A in place
        step("R11", 1, 3, vp(1, 3), 3, 64'h40, 7, 1, 1, 0, 1, 0);
        step("R11", 1, 0, vp(7, 3), 3, 64'h44, 0, 1, 1, 1, 1, 0);
        step("R11", 1, 3, vp(1, 3), 3, 64'h48, 7, 1, 0, 1, 1, 0);
        step("R11", 1, 0, vp(10, 3), 3, 64'h4c, 0, 1, 1, 1, 1, 0);
        // R12: block init zeroes the tag, so tag A now mismatches
        step("R12", 1, 4, vp(9, 3), 3, 64'h50, 0, 1, 1, 1, 1, 0);
        step("R12", 1, 0, vp(10, 3), 3, 64'h54, 0, 1, 1, 1, 1, 0);
        step("R1", 1, 6, vp(5, 3), 3, 64'h58, 0, 1, 1, 1, 1, 1);
        // R1: random mix over a few lines
        for (int n = 0; n < 3000; n++) begin
            int k, ln, tg;
            k = $urandom_range(0, 5); ln = $urandom_range(0, 3); tg = $urandom_range(0, 15);
            step("R1", bit'($urandom_range(0, 7) != 0), k, vp(tg, ln), ln,
                 64'($urandom), $urandom_range(0, 15), bit'($urandom_range(0, 3) != 0),
                 bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 3) != 0),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 15) == 0));
        end
        done = 1'b1;
        finish_run();
    end
endmodule